// File: doc/BRIEF.md
# GPIO Port Controller

This block gives an 8-bit microcontroller bus register access to two general-purpose I/O ports. The wide port has seven pins. Each of its pins has a data latch, a direction bit and an input pullup enable. The narrow port has two pins, each with a data latch and a direction bit. A serial transmitter/receiver can take both narrow pins away from software control. The block decodes byte addresses, accepts single-cycle writes and returns read data combinationally from the addressed register. It drives the pad output enables, the output values and the pullup controls.

Reads of a port data register return a mix of two sources. A bit whose direction is output returns its latch. A bit whose direction is input returns the pin level after a two-flop synchronizer. This choice follows the direction bits even while the serial function controls the narrow pins. The data latches have no reset, so software state written before a reset is still there after it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every direction bit and every pullup enable bit is 0. All pin output enables and all pullup controls are therefore low.
- R2: The wide-port pullup enable register sits at byte address 0x0F. Bits 6..0 are writable, and bit 7 always reads as 0.
- R3: A wide pin's pullup control is high only when its enable bit is 1 and its direction bit is 0 (input). It drops in the same cycle that the direction bit becomes 1.
- R4: The narrow-port data register sits at address 0x08 and its direction register at 0x0C. Only bits 1..0 exist in each, and bits 7..2 read as 0.
- R5: A reset does not change the data latches of either port. A value written before a reset reads back unchanged afterwards once the pin is set to output.
- R6: A register changes only on a clock edge where the write strobe is high and the address matches that register. Wide data is at 0x03 and wide direction at 0x07. Each wide output enable equals its direction bit (1 = output).
- R7: A data register read returns the latch for bits whose direction is 1. For bits whose direction is 0 it returns the pin level captured two clock edges earlier.
- R8: With the serial enable high, narrow pin 0 is driven from the serial TX input with its output enable at 1. Pin 1 has its output enable at 0, and the serial RX output follows pin 1 directly. With the serial enable low, RX reads 1.
- R9: With the serial enable high, the narrow direction bits still choose between latch and synchronized pin on a data register read.
- R10: Reads of an unmapped address return 0. Writes to an unmapped address change nothing. Bit 7 of the wide data and wide direction registers reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wpin_in | input | 7 | Wide port pin levels |
| wpin_out | output | 7 | Wide port output values |
| wpin_oe | output | 7 | Wide port output enables |
| wpin_pu | output | 7 | Wide port pullup controls |
| npin_in | input | 2 | Narrow port pin levels |
| npin_out | output | 2 | Narrow port output values |
| npin_oe | output | 2 | Narrow port output enables |
| ser_en | input | 1 | Serial function owns narrow pins |
| ser_tx | input | 1 | Serial transmit bit for narrow pin 0 |
| ser_rx | output | 1 | Narrow pin 1 level to the serial receiver |

## Verification
The serial takeover and a direction-register write can land in the same cycle. So can a pin edge moving through the synchronizer and a read that selects between latch and pin. The bench toggles the serial enable and TX while it rewrites the narrow direction bits. It also changes pin levels one cycle before the read it checks. A behavioural model compares every output and the read data on every clock. It keeps a history queue of pin samples and tracks which latch bits have been written, so that bits still holding their unknown power-up value are masked out of the comparison.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO port controller.
// Assumes an 8-bit data bus; register selection is carried as an enum.
package gpio_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_WDATA = 3'd1,
        SEL_WDIR  = 3'd2,
        SEL_WPUE  = 3'd3,
        SEL_NDATA = 3'd4,
        SEL_NDIR  = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for asynchronous pin levels.
// Assumes pins may change at any time; output lags input by two edges.
module gpio_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Capture pin levels through two flops; reset clears both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_addr_decode.sv
// Maps a byte address onto one of the port registers.
// Assumes all register addresses are distinct; anything else selects none.
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] A_WDATA = 8'h03,
    parameter logic [ADDR_W-1:0] A_WDIR  = 8'h07,
    parameter logic [ADDR_W-1:0] A_WPUE  = 8'h0F,
    parameter logic [ADDR_W-1:0] A_NDATA = 8'h08,
    parameter logic [ADDR_W-1:0] A_NDIR  = 8'h0C
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Compare the address against each register location.
    always_comb begin
        if (addr == A_WDATA)      sel = SEL_WDATA;
        else if (addr == A_WDIR)  sel = SEL_WDIR;
        else if (addr == A_WPUE)  sel = SEL_WPUE;
        else if (addr == A_NDATA) sel = SEL_NDATA;
        else if (addr == A_NDIR)  sel = SEL_NDIR;
        else                      sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_wide_port.sv
// Wide GPIO port: per-pin data latch, direction and pullup enable.
// Assumes write strobes are already qualified by address. Data latches
// have no reset. A pullup is gated off combinationally while its pin drives.
module gpio_wide_port #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_data,
    input  logic         we_dir,
    input  logic         we_pue,
    input  logic [N-1:0] wval,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe,
    output logic [N-1:0] pin_pu,
    output logic [N-1:0] rd_data,
    output logic [N-1:0] rd_dir,
    output logic [N-1:0] rd_pue
);
    logic [N-1:0] lat;
    logic [N-1:0] dir;
    logic [N-1:0] pue;
    logic [N-1:0] pin_s;

    // Data latch: loaded by writes only, untouched by reset.
    always_ff @(posedge clk) begin
        if (we_data) lat <= wval;
    end

    // Direction and pullup enables: cleared by reset, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= '0;
            pue <= '0;
        end else begin
            if (we_dir) dir <= wval;
            if (we_pue) pue <= wval;
        end
    end

    gpio_sync #(.W(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    // Per-pin pad controls and read-back source selection.
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pin_pu[i]  = pue[i] & ~dir[i];
        assign rd_data[i] = dir[i] ? lat[i] : pin_s[i];
    end

    assign pin_out = lat;
    assign pin_oe  = dir;
    assign rd_dir  = dir;
    assign rd_pue  = pue;
endmodule

// File: rtl/gpio_narrow_port.sv
// Narrow GPIO port that a serial transmitter/receiver may take over.
// Assumes N >= 2 with TX on pin TX_BIT and RX on pin RX_BIT. The serial
// function overrides direction, but read-back still follows the direction bits.
module gpio_narrow_port #(
    parameter int N      = 2,
    parameter int TX_BIT = 0,
    parameter int RX_BIT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_data,
    input  logic         we_dir,
    input  logic [N-1:0] wval,
    input  logic [N-1:0] pin_in,
    input  logic         ser_en,
    input  logic         ser_tx,
    output logic         ser_rx,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe,
    output logic [N-1:0] rd_data,
    output logic [N-1:0] rd_dir
);
    logic [N-1:0] lat;
    logic [N-1:0] dir;
    logic [N-1:0] pin_s;

    // Data latch: loaded by writes only, untouched by reset.
    always_ff @(posedge clk) begin
        if (we_data) lat <= wval;
    end

    // Direction register: cleared by reset, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir <= '0;
        else if (we_dir) dir <= wval;
    end

    gpio_sync #(.W(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    // Per-pin pad control with serial override on the TX and RX pins.
    for (genvar i = 0; i < N; i++) begin : g_pin
        if (i == TX_BIT) begin : g_tx
            assign pin_oe[i]  = ser_en | dir[i];
            assign pin_out[i] = ser_en ? ser_tx : lat[i];
        end else if (i == RX_BIT) begin : g_rx
            assign pin_oe[i]  = ~ser_en & dir[i];
            assign pin_out[i] = lat[i];
        end else begin : g_plain
            assign pin_oe[i]  = dir[i];
            assign pin_out[i] = lat[i];
        end
        assign rd_data[i] = dir[i] ? lat[i] : pin_s[i];
    end

    assign ser_rx = ser_en ? pin_in[RX_BIT] : 1'b1;
    assign rd_dir = dir;
endmodule

// File: rtl/gpio_port_ctrl.sv
// Top of the GPIO port controller: address decode, write strobes, read mux.
// Assumes port widths below the bus width; read data is combinational
// from bus_addr, and writes land on the clock edge with bus_wr high.
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                WIDE_N   = 7,
    parameter int                NARROW_N = 2,
    parameter logic [ADDR_W-1:0] A_WDATA  = 8'h03,
    parameter logic [ADDR_W-1:0] A_WDIR   = 8'h07,
    parameter logic [ADDR_W-1:0] A_WPUE   = 8'h0F,
    parameter logic [ADDR_W-1:0] A_NDATA  = 8'h08,
    parameter logic [ADDR_W-1:0] A_NDIR   = 8'h0C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [WIDE_N-1:0]   wpin_in,
    output logic [WIDE_N-1:0]   wpin_out,
    output logic [WIDE_N-1:0]   wpin_oe,
    output logic [WIDE_N-1:0]   wpin_pu,
    input  logic [NARROW_N-1:0] npin_in,
    output logic [NARROW_N-1:0] npin_out,
    output logic [NARROW_N-1:0] npin_oe,
    input  logic                ser_en,
    input  logic                ser_tx,
    output logic                ser_rx
);
    reg_sel_e            sel;
    logic [WIDE_N-1:0]   w_rd_data, w_rd_dir, w_rd_pue;
    logic [NARROW_N-1:0] n_rd_data, n_rd_dir;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:WIDE_N];

    gpio_addr_decode #(
        .ADDR_W (ADDR_W),
        .A_WDATA(A_WDATA),
        .A_WDIR (A_WDIR),
        .A_WPUE (A_WPUE),
        .A_NDATA(A_NDATA),
        .A_NDIR (A_NDIR)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    gpio_wide_port #(.N(WIDE_N)) u_wide (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_data(bus_wr && (sel == SEL_WDATA)),
        .we_dir (bus_wr && (sel == SEL_WDIR)),
        .we_pue (bus_wr && (sel == SEL_WPUE)),
        .wval   (bus_wdata[WIDE_N-1:0]),
        .pin_in (wpin_in),
        .pin_out(wpin_out),
        .pin_oe (wpin_oe),
        .pin_pu (wpin_pu),
        .rd_data(w_rd_data),
        .rd_dir (w_rd_dir),
        .rd_pue (w_rd_pue)
    );

    gpio_narrow_port #(.N(NARROW_N), .TX_BIT(0), .RX_BIT(1)) u_narrow (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_data(bus_wr && (sel == SEL_NDATA)),
        .we_dir (bus_wr && (sel == SEL_NDIR)),
        .wval   (bus_wdata[NARROW_N-1:0]),
        .pin_in (npin_in),
        .ser_en (ser_en),
        .ser_tx (ser_tx),
        .ser_rx (ser_rx),
        .pin_out(npin_out),
        .pin_oe (npin_oe),
        .rd_data(n_rd_data),
        .rd_dir (n_rd_dir)
    );

    // Read mux: zero-extend the selected register, zero for unmapped.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_WDATA: bus_rdata = BUS_W'(w_rd_data);
            SEL_WDIR:  bus_rdata = BUS_W'(w_rd_dir);
            SEL_WPUE:  bus_rdata = BUS_W'(w_rd_pue);
            SEL_NDATA: bus_rdata = BUS_W'(n_rd_data);
            SEL_NDIR:  bus_rdata = BUS_W'(n_rd_dir);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctrl_sva.sv
// Property checker for the GPIO port controller, bound to the top.
// Assumes the default register addresses passed in from the bound instance.
module gpio_port_ctrl_sva #(
    parameter int                ADDR_W   = 8,
    parameter int                WIDE_N   = 7,
    parameter int                NARROW_N = 2,
    parameter logic [ADDR_W-1:0] A_WDIR   = 8'h07,
    parameter logic [ADDR_W-1:0] A_WPUE   = 8'h0F,
    parameter logic [ADDR_W-1:0] A_NDATA  = 8'h08
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic [WIDE_N-1:0]   wpin_oe,
    input logic [WIDE_N-1:0]   wpin_pu,
    input logic [NARROW_N-1:0] npin_oe,
    input logic [NARROW_N-1:0] npin_out,
    input logic                ser_en,
    input logic                ser_tx
);
    // R1: first cycle out of reset shows all pins input, pullups off
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !ser_en) |-> (wpin_oe == '0 && wpin_pu == '0 && npin_oe == '0));

    // R2: top bit of the pullup enable register reads as zero
    p_pue_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_WPUE) |-> (bus_rdata[7] == 1'b0));

    // R3: no pin has its pullup on while it drives
    p_pu_off_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wpin_pu & wpin_oe) == '0);

    // R4: unimplemented narrow data bits read as zero
    p_ndata_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_NDATA) |-> (bus_rdata[7:2] == 6'd0));

    // R6: a direction write shows on the output enables one edge later
    p_dir_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_WDIR) |=> (wpin_oe == $past(bus_wdata[WIDE_N-1:0])));

    // R8: serial mode drives TX pin and releases RX pin
    p_serial_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> (npin_oe[0] && !npin_oe[1] && npin_out[0] == ser_tx));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_sva #(
    .ADDR_W  (ADDR_W),
    .WIDE_N  (WIDE_N),
    .NARROW_N(NARROW_N),
    .A_WDIR  (A_WDIR),
    .A_WPUE  (A_WPUE),
    .A_NDATA (A_NDATA)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .wpin_oe  (wpin_oe),
    .wpin_pu  (wpin_pu),
    .npin_oe  (npin_oe),
    .npin_out (npin_out),
    .ser_en   (ser_en),
    .ser_tx   (ser_tx)
);

// File: tb/gpio_port_ctrl_tb.sv
// Bench for gpio_port_ctrl: directed stimulus plus a behavioural model
// compared against every output on every falling clock edge.
module gpio_port_ctrl_tb;
    localparam logic [7:0] AWD = 8'h03, AWR = 8'h07, APU = 8'h0F, AND_ = 8'h08, ANR = 8'h0C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [6:0] wpin_in = 7'h2A;
    logic [6:0] wpin_out, wpin_oe, wpin_pu;
    logic [1:0] npin_in = 2'b10;
    logic [1:0] npin_out, npin_oe;
    logic       ser_en = 1'b0;
    logic       ser_tx = 1'b0;
    logic       ser_rx;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit run = 0;

    always #10 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wpin_in(wpin_in), .wpin_out(wpin_out), .wpin_oe(wpin_oe), .wpin_pu(wpin_pu),
        .npin_in(npin_in), .npin_out(npin_out), .npin_oe(npin_oe),
        .ser_en(ser_en), .ser_tx(ser_tx), .ser_rx(ser_rx)
    );

    // Reference model state
    logic [6:0] m_wdir = '0, m_wpue = '0, m_wlat = '0, m_wknown = '0;
    logic [1:0] m_ndir = '0, m_nlat = '0, m_nknown = '0;
    logic [6:0] hw[$];
    logic [1:0] hn[$];

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wdir = '0; m_wpue = '0; m_ndir = '0;
            hw.delete(); hn.delete();
        end else begin
            hw.push_front(wpin_in); hn.push_front(npin_in);
            if (hw.size() > 4) void'(hw.pop_back());
            if (hn.size() > 4) void'(hn.pop_back());
            if (bus_wr) begin
                case (bus_addr)
                    AWD:  begin m_wlat = bus_wdata[6:0]; m_wknown = '1; end
                    AWR:  m_wdir = bus_wdata[6:0];
                    APU:  m_wpue = bus_wdata[6:0];
                    AND_: begin m_nlat = bus_wdata[1:0]; m_nknown = '1; end
                    ANR:  m_ndir = bus_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && run && !done) begin
            logic [6:0] ws;
            logic [1:0] ns;
            logic [7:0] er, mk;
            logic [1:0] eoe, eout, omk;
            string tag;
            ws = (hw.size() >= 2) ? hw[1] : 7'h0;
            ns = (hn.size() >= 2) ? hn[1] : 2'h0;
            mk = 8'hFF;
            tag = "R10";
            case (bus_addr)
                AWD:  begin er = {1'b0, (m_wdir & m_wlat) | (~m_wdir & ws)};
                            mk = {1'b1, ~m_wdir | m_wknown}; tag = "R7"; end
                AWR:  begin er = {1'b0, m_wdir}; tag = "R6"; end
                APU:  begin er = {1'b0, m_wpue}; tag = "R2"; end
                AND_: begin er = {6'd0, (m_ndir & m_nlat) | (~m_ndir & ns)};
                            mk = {6'h3F, ~m_ndir | m_nknown}; tag = "R9"; end
                ANR:  begin er = {6'd0, m_ndir}; tag = "R4"; end
                default: er = 8'h00;
            endcase
            chk(tag, bus_rdata & mk, er & mk);
            chk("R6", wpin_oe, m_wdir);
            chk("R3", wpin_pu, m_wpue & ~m_wdir);
            chk("R5", wpin_out & m_wknown, m_wlat & m_wknown);
            eoe  = ser_en ? 2'b01 : m_ndir;
            eout = ser_en ? {m_nlat[1], ser_tx} : m_nlat;
            omk  = ser_en ? {m_nknown[1], 1'b1} : m_nknown;
            chk("R8", npin_oe, eoe);
            chk("R8", npin_out & omk, eout & omk);
            chk("R8", ser_rx, ser_en ? npin_in[1] : 1'b1);
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        chk(req, bus_rdata, exp);
        #2;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        run = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", wpin_oe, 0);
        chk("R1", wpin_pu, 0);
        chk("R1", npin_oe, 0);
        #2;
        rd(AWR, 8'h00, "R1");
        rd(APU, 8'h00, "R1");
        // R2: writable enables, bit 7 reads 0
        wr(APU, 8'hFF);
        rd(APU, 8'h7F, "R2");
        chk("R3", wpin_pu, 7'h7F);
        // R3: pullups of output pins drop with the direction write
        wr(AWR, 8'h0F);
        chk("R3", wpin_pu, 7'h70);
        chk("R6", wpin_oe, 7'h0F);
        // R7: mixed latch/pin read
        wr(AWD, 8'h55);
        rd(AWD, 8'h25, "R7");
        // R7: two-edge synchronizer latency
        wpin_in = 7'h7F;
        bus_addr = AWD;
        @(negedge clk); chk("R7", bus_rdata, 8'h25);
        @(negedge clk); chk("R7", bus_rdata, 8'h75);
        #2;
        // R4: narrow port registers
        wr(AND_, 8'hFF);
        rd(AND_, 8'h02, "R7");
        wr(ANR, 8'hFF);
        rd(ANR, 8'h03, "R4");
        rd(AND_, 8'h03, "R4");
        // R10: unmapped address and R6 address qualification
        rd(8'h20, 8'h00, "R10");
        wr(8'h20, 8'hFF);
        rd(AWR, 8'h0F, "R6");
        wr(AWR, 8'hFF);
        rd(AWR, 8'h7F, "R10");
        // R5: latches survive reset
        @(negedge clk); #2 rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd(APU, 8'h00, "R1");
        wr(ANR, 8'h03);
        rd(AND_, 8'h03, "R5");
        wr(AWR, 8'h7F);
        rd(AWD, 8'h55, "R5");
        // R8: serial takeover
        npin_in = 2'b00;
        ser_tx = 1'b1;
        ser_en = 1'b1;
        idle(3);
        chk("R8", npin_oe, 2'b01);
        chk("R8", npin_out[0], 1);
        chk("R8", ser_rx, 0);
        rd(AND_, 8'h03, "R9");
        npin_in = 2'b11;
        ser_tx = 1'b0;
        #1;
        chk("R8", ser_rx, 1);
        chk("R8", npin_out[0], 0);
        // R9: direction bits still pick the read source, written as serial toggles
        bus_addr = ANR; bus_wdata = 8'h00; bus_wr = 1'b1; ser_tx = 1'b1;
        @(negedge clk); #2 bus_wr = 1'b0;
        idle(2);
        rd(AND_, 8'h03, "R9");
        npin_in = 2'b01;
        idle(2);
        rd(AND_, 8'h01, "R9");
        // R8: release serial and switch direction in the same cycle
        bus_addr = ANR; bus_wdata = 8'h02; bus_wr = 1'b1; ser_en = 1'b0;
        @(negedge clk); #2 bus_wr = 1'b0;
        chk("R8", ser_rx, 1);
        chk("R8", npin_oe, 2'b10);
        idle(3);
        finish_run();
    end
endmodule